// File: doc/BRIEF.md
# Raster Sprite Channel

This block is one sprite channel of a raster video generator. A register bus writes four 16-bit locations: a placement word, a control word and two image planes. From these the block forms a 9-bit horizontal start, a 9-bit vertical start, a 9-bit vertical end and an attach flag. It watches the beam counters. When the horizontal count equals the horizontal start on a line inside the vertical window, it copies both image planes into shift registers. It then emits one 2-bit pixel per pixel-clock enable.

Which location is written decides whether the channel is armed. A write to image plane A arms it, and a write to the control word disarms it. Fetching the data, priority against playfields and colour merging of attached pairs are done downstream. The attach flag is exported for that purpose.

Top module: `sprite_channel`

## Requirements
- R1: While reset is held and after it is released, with no register writes, `pix_out` is 0 and `attach_out` is 0, and the channel is disarmed.
- R2: A write with `wr_sel`=0 (placement) sets vertical start bits 7..0 from `wr_data[15:8]` and horizontal start bits 8..1 from `wr_data[7:0]`.
- R3: A write with `wr_sel`=1 (control) sets vertical end bits 7..0 from `wr_data[15:8]`, vertical start bit 8 from bit 2, vertical end bit 8 from bit 1 and horizontal start bit 0 from bit 0. Bits 6..3 have no effect.
- R4: A control write disarms the channel from the next cycle. A write with `wr_sel`=2 (plane A) arms it from the next cycle. A write with `wr_sel`=3 writes plane B and leaves the armed state as it is.
- R5: A load happens in a cycle where all of these hold: the channel is armed, `pix_en` is 1, `beam_h` equals the horizontal start, and `beam_v` is inside the window. A load copies both planes into the shifters.
- R6: After a load, `pix_out` is {B bit 15, A bit 15} from the next cycle. Each following cycle with `pix_en`=1 moves to the next lower bit. `pix_out` holds its value when `pix_en`=0.
- R7: After 16 pixels `pix_out` returns to 0. A new load during shifting restarts the 16-pixel run with fresh data.
- R8: No load happens when `beam_v` is below the vertical start or at or above the vertical end. Pixel value 0 is transparent.
- R9: `attach_out` equals control bit 7 of the most recent control write.
- R10: A load uses the register values held before a write in the same cycle. A control write in the load cycle does not cancel that load. A plane A write in the load cycle loads the old plane A data.
- R11: Writes to the planes while shifting do not change the pixels of the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 placement, 1 control, 2 plane A, 3 plane B |
| wr_data | input | 16 | Register write data |
| pix_en | input | 1 | Pixel clock enable |
| beam_h | input | 9 | Horizontal beam count |
| beam_v | input | 9 | Vertical beam count |
| pix_out | output | 2 | Sprite pixel {plane B bit, plane A bit}, 0 is transparent |
| attach_out | output | 1 | Stored attach flag |

## Verification
A register write and a comparator load can fall in the same clock edge. This happens with a control write (disarm) or a plane A write (arm with new data). The bench makes this happen by writing at the exact beam position of the horizontal start. It also writes a plane, and moves the start, in the middle of a 16-pixel run. A behavioural queue model resolves every such edge: it decides the load from the pre-write state first and applies the write afterwards. The model is compared against `pix_out` and `attach_out` on every clock, so the bench catches a design that lets the write take effect before the load.

// File: rtl/sprite_pkg.sv
package sprite_pkg;

  localparam int unsigned SPR_WORD_W  = 16;
  localparam int unsigned SPR_COORD_W = 9;

  // control word bit positions (decoded by the register block)
  localparam int unsigned CTL_ATTACH_BIT = 7;
  localparam int unsigned CTL_VS_HI_BIT  = 2;
  localparam int unsigned CTL_VE_HI_BIT  = 1;
  localparam int unsigned CTL_HS_LO_BIT  = 0;

  typedef enum logic [1:0] {
    SEL_PLACE = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_IMG_A = 2'd2,
    SEL_IMG_B = 2'd3
  } spr_sel_e;

  typedef struct packed {
    logic [SPR_COORD_W-1:0] h_start;
    logic [SPR_COORD_W-1:0] v_start;
    logic [SPR_COORD_W-1:0] v_end;
    logic                   attach;
  } spr_place_t;

endpackage

// File: rtl/sprite_regs.sv
module sprite_regs
  import sprite_pkg::*;
#(
  parameter int unsigned WORD_W = SPR_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  output spr_place_t        place,
  output logic [WORD_W-1:0] img_a,
  output logic [WORD_W-1:0] img_b,
  output logic              armed
);

  localparam int unsigned HALF_W = WORD_W / 2;

  spr_place_t        place_q, place_d;
  logic [WORD_W-1:0] img_a_q, img_a_d;
  logic [WORD_W-1:0] img_b_q, img_b_d;
  logic              armed_q, armed_d;
  spr_sel_e          sel;

  assign sel = spr_sel_e'(wr_sel);

  always_comb begin
    place_d = place_q;
    img_a_d = img_a_q;
    img_b_d = img_b_q;
    armed_d = armed_q;
    unique case (sel)
      SEL_PLACE: begin
        place_d.v_start[HALF_W-1:0]        = wr_data[WORD_W-1:HALF_W];
        place_d.h_start[SPR_COORD_W-1:1]   = wr_data[HALF_W-1:0];
      end
      SEL_CTRL: begin
        place_d.v_end[HALF_W-1:0]          = wr_data[WORD_W-1:HALF_W];
        place_d.attach                     = wr_data[CTL_ATTACH_BIT];
        place_d.v_start[SPR_COORD_W-1]     = wr_data[CTL_VS_HI_BIT];
        place_d.v_end[SPR_COORD_W-1]       = wr_data[CTL_VE_HI_BIT];
        place_d.h_start[0]                 = wr_data[CTL_HS_LO_BIT];
        armed_d                            = 1'b0;
      end
      SEL_IMG_A: begin
        img_a_d = wr_data;
        armed_d = 1'b1;
      end
      SEL_IMG_B: img_b_d = wr_data;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      place_q <= '0;
      img_a_q <= '0;
      img_b_q <= '0;
      armed_q <= 1'b0;
    end else if (wr_en) begin
      place_q <= place_d;
      img_a_q <= img_a_d;
      img_b_q <= img_b_d;
      armed_q <= armed_d;
    end
  end

  assign place = place_q;
  assign img_a = img_a_q;
  assign img_b = img_b_q;
  assign armed = armed_q;

  AST_CTRL_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_CTRL) |=> !armed); // R4
  AST_IMG_A_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_IMG_A) |=> armed); // R4
  AST_ATTACH_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_CTRL) |=> (place.attach == $past(wr_data[CTL_ATTACH_BIT]))); // R9

endmodule

// File: rtl/sprite_cmp.sv
module sprite_cmp
  import sprite_pkg::*;
#(
  parameter int unsigned IMG_W   = SPR_WORD_W,
  parameter int unsigned COORD_W = SPR_COORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               armed,
  input  logic               pix_en,
  input  logic [COORD_W-1:0] beam_h,
  input  logic [COORD_W-1:0] beam_v,
  input  spr_place_t         place,
  output logic               load,
  output logic               shift,
  output logic               active
);

  localparam int unsigned CNT_W = $clog2(IMG_W + 1);
  localparam logic [CNT_W-1:0] RUN_LEN = CNT_W'(IMG_W);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             v_inside;
  logic             h_hit;
  logic             cnt_en;

  assign v_inside = (beam_v >= place.v_start) && (beam_v < place.v_end);
  assign h_hit    = (beam_h == place.h_start);
  assign load     = armed && pix_en && h_hit && v_inside;
  assign active   = (cnt_q != '0);
  assign shift    = pix_en && !load && active;
  assign cnt_en   = load || shift;

  always_comb begin
    cnt_d = cnt_q;
    if (load)       cnt_d = RUN_LEN;
    else if (shift) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= RUN_LEN); // R7
  AST_LOAD_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == RUN_LEN)); // R7
  AST_DRAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R7
  AST_DISARMED_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !load); // R4

endmodule

// File: rtl/sprite_shreg.sv
module sprite_shreg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         msb
);

  logic [W-1:0] sh_q, sh_d;
  logic         sh_en;

  assign sh_en = load || shift;

  always_comb begin
    sh_d = sh_q;
    if (load)       sh_d = din;
    else if (shift) sh_d = {sh_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  assign msb = sh_q[W-1];

endmodule

// File: rtl/sprite_channel.sv
module sprite_channel
  import sprite_pkg::*;
#(
  parameter int unsigned IMG_W   = SPR_WORD_W,
  parameter int unsigned COORD_W = SPR_COORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [IMG_W-1:0]   wr_data,
  input  logic               pix_en,
  input  logic [COORD_W-1:0] beam_h,
  input  logic [COORD_W-1:0] beam_v,
  output logic [1:0]         pix_out,
  output logic               attach_out
);

  localparam int unsigned PLANES = 2;

  logic             rst_meta_q, rst_sync_q;
  spr_place_t       place;
  logic [IMG_W-1:0] img_a, img_b;
  logic             armed, load, shift, active;
  logic [PLANES-1:0][IMG_W-1:0] plane_data;
  logic [PLANES-1:0]            plane_msb;

  // reset asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  sprite_regs #(.WORD_W(IMG_W)) i_regs (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .place   (place),
    .img_a   (img_a),
    .img_b   (img_b),
    .armed   (armed)
  );

  sprite_cmp #(.IMG_W(IMG_W), .COORD_W(COORD_W)) i_cmp (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .armed   (armed),
    .pix_en  (pix_en),
    .beam_h  (beam_h),
    .beam_v  (beam_v),
    .place   (place),
    .load    (load),
    .shift   (shift),
    .active  (active)
  );

  assign plane_data[0] = img_a;
  assign plane_data[1] = img_b;

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    sprite_shreg #(.W(IMG_W)) i_shreg (
      .clk   (clk),
      .rst_n (rst_sync_q),
      .load  (load),
      .shift (shift),
      .din   (plane_data[p]),
      .msb   (plane_msb[p])
    );
  end

  assign pix_out    = active ? plane_msb : 2'b00;
  assign attach_out = place.attach;

  AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_sync_q)
    load |=> (pix_out == {$past(img_b[IMG_W-1]), $past(img_a[IMG_W-1])})); // R6
  AST_HOLD_NO_PE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!pix_en && !load) |=> $stable(pix_out)); // R6
  AST_NO_LOAD_BELOW: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (beam_v < place.v_start) |-> !load); // R8

endmodule

// File: tb/test_sprite_channel.sv
module test_sprite_channel;

  localparam int HLEN = 320;
  localparam logic [1:0] S_PLACE = 2'd0, S_CTRL = 2'd1, S_A = 2'd2, S_B = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [15:0] wr_data;
  logic        pix_en;
  logic [8:0]  beam_h, beam_v;
  logic [1:0]  pix_out;
  logic        attach_out;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  string phase = "R1";

  // reference model state
  logic [8:0]  m_hs, m_vs, m_ve;
  logic        m_att, m_armed;
  logic [15:0] m_a, m_b;
  logic [1:0]  m_q[$];

  always #4 clk = ~clk;

  sprite_channel i_sprite_channel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pix_en(pix_en), .beam_h(beam_h), .beam_v(beam_v),
    .pix_out(pix_out), .attach_out(attach_out)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hs = 0; m_vs = 0; m_ve = 0; m_att = 0; m_armed = 0; m_a = 0; m_b = 0;
      m_q.delete();
    end else begin
      if (m_armed && pix_en && beam_h == m_hs && beam_v >= m_vs && beam_v < m_ve) begin
        m_q.delete();
        for (int i = 15; i >= 0; i--) m_q.push_back({m_b[i], m_a[i]});
      end else if (pix_en && m_q.size() > 0) begin
        void'(m_q.pop_front());
      end
      if (wr_en) begin
        case (wr_sel)
          S_PLACE: begin m_vs[7:0] = wr_data[15:8]; m_hs[8:1] = wr_data[7:0]; end
          S_CTRL: begin
            m_ve[7:0] = wr_data[15:8]; m_att = wr_data[7];
            m_vs[8] = wr_data[2]; m_ve[8] = wr_data[1]; m_hs[0] = wr_data[0];
            m_armed = 1'b0;
          end
          S_A: begin m_a = wr_data; m_armed = 1'b1; end
          default: m_b = wr_data;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    logic [1:0] exp_pix;
    cycles++;
    exp_pix = (m_q.size() > 0) ? m_q[0] : 2'b00;
    vectors++;
    if (pix_out !== exp_pix || attach_out !== m_att) begin
      miscompares++;
      $display("FAIL %s: pix_out=%0h attach_out=%0b expected pix_out=%0h attach_out=%0b (v=%0d h=%0d)",
               phase, pix_out, attach_out, exp_pix, m_att, beam_v, beam_h);
    end
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_line(input int v, input int pe_div, input bit do_w,
                          input int wh, input logic [1:0] ws, input logic [15:0] wd);
    for (int h = 0; h < HLEN; h++) begin
      for (int p = 0; p < pe_div; p++) begin
        @(negedge clk);
        beam_v = 9'(v); beam_h = 9'(h);
        pix_en = (p == pe_div - 1);
        wr_en  = do_w && (h == wh) && (p == pe_div - 1);
        wr_sel = ws; wr_data = wd;
      end
    end
    @(negedge clk);
    pix_en = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_sel = 0; wr_data = 0; pix_en = 0; beam_h = 0; beam_v = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_line(12, 1, 0, 0, 0, 0);                 // R1: reset state, nothing armed

    phase = "R2";
    wr(S_PLACE, 16'h0A32);                        // v start 10, h start bits 8..1 = 0x32
    phase = "R3";
    wr(S_CTRL, 16'h14F9);                         // v end 20, attach, bits 6..3 set, h start bit 0
    phase = "R9";
    wr(S_B, 16'hA5C3);
    phase = "R4";
    wr(S_A, 16'h0FF0);                            // arms
    phase = "R5";
    run_line(12, 1, 0, 0, 0, 0);
    phase = "R6";
    run_line(13, 3, 0, 0, 0, 0);                  // slow pixel enable, holding between pixels
    phase = "R8";
    run_line(9, 1, 0, 0, 0, 0);
    run_line(20, 1, 0, 0, 0, 0);
    run_line(19, 1, 0, 0, 0, 0);

    phase = "R7";                                 // move start mid-run to reload
    run_line(14, 1, 1, 106, S_PLACE, 16'h0A37);

    phase = "R4";
    wr(S_CTRL, 16'h14F9);
    run_line(15, 1, 0, 0, 0, 0);
    wr(S_A, 16'h8001);
    run_line(15, 1, 0, 0, 0, 0);

    phase = "R10";                                // control write on the load cycle
    run_line(16, 1, 1, 111, S_CTRL, 16'h14F9);
    run_line(17, 1, 0, 0, 0, 0);
    wr(S_A, 16'h1111);
    run_line(17, 1, 1, 111, S_A, 16'h7E7E);       // plane A write on the load cycle
    run_line(18, 1, 0, 0, 0, 0);

    phase = "R11";
    run_line(18, 1, 1, 114, S_B, 16'hFFFF);
    run_line(19, 1, 1, 115, S_A, 16'h0000);
    run_line(18, 1, 0, 0, 0, 0);

    phase = "R3";                                 // high bits of start and end
    wr(S_PLACE, 16'h0090);
    wr(S_CTRL, 16'h0207);                         // v start 0x100, v end 0x102, attach cleared
    phase = "R9";
    run_line(0, 1, 0, 0, 0, 0);
    phase = "R3";
    wr(S_A, 16'hC3A5);
    run_line(0, 1, 0, 0, 0, 0);
    run_line(255, 1, 0, 0, 0, 0);
    run_line(256, 1, 0, 0, 0, 0);
    run_line(257, 2, 0, 0, 0, 0);
    run_line(258, 1, 0, 0, 0, 0);

    phase = "R1";
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run_line(256, 1, 0, 0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule